// File: doc/BRIEF.md
# DMA Channel Bus Arbiter with Interrupt Hold-Off

The block decides which of eight DMA channels may use the shared bus, one at a time. When some channel is requesting and nothing holds DMA off, it raises a bus request to the CPU. Once the CPU acknowledges, it grants the highest-priority requesting channel. The grant stays in place until the transfer engine reports the final breakpoint of that channel's transfer. After each grant the bus request drops and the CPU must release the acknowledge before another request is raised, so the CPU gets the bus back between channels.

DMA can be held off in two ways. The first is a pending interrupt whose level beats a programmable hold-cancel threshold. The second is a nonzero value in a software hold register. If a hold appears during a transfer, the channel is released at the next breakpoint and its request stays pending. If a hold is present while the block is idle, no bus request is raised. The two registers are written through a small write-only port. The state machine has four states. IDLE has no bus request. ASK raises the bus request and waits for the acknowledge. XFER holds a channel grant. GIVE has the bus request low and waits for the acknowledge to drop. The transitions are IDLE→ASK, ASK→XFER, ASK→GIVE, XFER→GIVE and GIVE→IDLE.

Top module: `dma_hold_arbiter`

## Requirements
- R1: On the move from ASK to XFER, the block grants the lowest-numbered channel whose request bit was high in the cycle before. Bit 0 has the highest priority. `grant` is one-hot, and bit i stands for channel i.
- R2: While in XFER, the grant stays the same and requests from other channels are not taken. The grant ends only on a breakpoint, which is a `xfer_done` pulse, and it ends there when `xfer_last` is high or a hold is active.
- R3: IDLE goes to ASK when at least one request is high and no hold is active. ASK goes to XFER only when `bus_ack` is high, a request is present and no hold is active.
- R4: When a grant ends, the block goes to GIVE with `bus_req` low for at least one cycle. It goes back to IDLE only after `bus_ack` is low. A later grant therefore needs a fresh acknowledge.
- R5: An interrupt hold is active when `irq_valid` is high and `irq_level` is numerically less than the threshold register. A smaller level means a higher priority.
- R6: The threshold register is written at `reg_addr`=0 and resets to 31. Right after reset, any valid interrupt with a level from 0 to 30 holds DMA off.
- R7: The software hold register is written at `reg_addr`=1. Any nonzero value holds DMA off, whatever the interrupt state, and writing zero removes that hold.
- R8: A breakpoint that arrives with a hold active ends the grant (XFER→GIVE) even when `xfer_last` is low. The suspended channel's request stays pending and is granted again through normal arbitration once the hold clears.
- R9: While a hold is active, IDLE stays IDLE. ASK goes to GIVE without granting.
- R10: During and right after reset, `bus_req`, `grant` and `xfer_active` are all low, and the hold register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_req | input | NCH | Per-channel transfer requests |
| xfer_done | input | 1 | One-cycle breakpoint pulse from the transfer engine |
| xfer_last | input | 1 | Qualifies `xfer_done` as the final breakpoint of the transfer |
| irq_valid | input | 1 | An interrupt is pending |
| irq_level | input | LVL_W | Level of the highest pending interrupt (smaller is more urgent) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the threshold register, 1 selects the hold register |
| reg_wdata | input | LVL_W | Register write data |
| bus_ack | input | 1 | CPU has released the bus |
| bus_req | output | 1 | Bus request to the CPU |
| grant | output | NCH | One-hot channel grant |
| xfer_active | output | 1 | A channel currently owns the bus |

## Verification
The bench builds the block with its default parameters: eight channels and 5-bit interrupt levels. With these values every priority position from channel 0 to channel 7 can be reached. The threshold reset value of 31 and the boundary where the level equals the threshold can both be tested directly. A CPU model in the bench follows `bus_req` with one cycle of delay, so the GIVE handshake runs on every release.

// File: rtl/dha_pkg.sv
package dha_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ASK  = 2'd1,
        ST_XFER = 2'd2,
        ST_GIVE = 2'd3
    } dha_state_e;
endpackage

// File: rtl/dha_ctrl_regs.sv
module dha_ctrl_regs #(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_addr,
    input  logic [LVL_W-1:0] reg_wdata,
    input  logic             irq_valid,
    input  logic [LVL_W-1:0] irq_level,
    output logic             hold
);
    localparam logic [LVL_W-1:0] THR_RESET = {LVL_W{1'b1}};

    logic [LVL_W-1:0] thr_q;
    logic [LVL_W-1:0] swhold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q    <= THR_RESET;
            swhold_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == 1'b0) thr_q    <= reg_wdata;
            else                  swhold_q <= reg_wdata;
        end
    end

    always_comb begin
        hold = (irq_valid && (irq_level < thr_q)) || (swhold_q != '0);
    end

    // R6
    thr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 1'b0) |=> thr_q == $past(reg_wdata));
    // R7
    swhold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 1'b1 && reg_wdata != '0) |=> hold);
endmodule

// File: rtl/dha_prio_pick.sv
module dha_prio_pick #(
    parameter int NCH = 8
) (
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] pick
);
    logic [NCH:0] blocked;
    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < NCH; i++) begin : g_chain
        assign pick[i]      = req[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | req[i];
    end
endmodule

// File: rtl/dha_seq_fsm.sv
module dha_seq_fsm
    import dha_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           any_req,
    input  logic [NCH-1:0] pick,
    input  logic           hold,
    input  logic           bus_ack,
    input  logic           xfer_done,
    input  logic           xfer_last,
    output logic           bus_req,
    output logic [NCH-1:0] grant,
    output logic           xfer_active
);
    dha_state_e     state_q, state_d;
    logic [NCH-1:0] grant_q, grant_d;

    always_comb begin
        state_d = state_q;
        grant_d = grant_q;
        unique case (state_q)
            ST_IDLE: if (any_req && !hold) state_d = ST_ASK;
            ST_ASK: begin
                if (hold) begin
                    state_d = ST_GIVE;
                end else if (bus_ack) begin
                    if (any_req) begin
                        state_d = ST_XFER;
                        grant_d = pick;
                    end else begin
                        state_d = ST_GIVE;
                    end
                end
            end
            ST_XFER: begin
                if (xfer_done && (xfer_last || hold)) begin
                    state_d = ST_GIVE;
                    grant_d = '0;
                end
            end
            ST_GIVE: if (!bus_ack) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grant_q <= '0;
        end else begin
            state_q <= state_d;
            grant_q <= grant_d;
        end
    end

    always_comb begin
        bus_req     = (state_q == ST_ASK) || (state_q == ST_XFER);
        xfer_active = (state_q == ST_XFER);
        grant       = xfer_active ? grant_q : '0;
    end

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active |-> $onehot(grant));
    // R2
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && !xfer_done) |=> xfer_active && $stable(grant));
    // R4
    give_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_active) |-> !bus_req);
    // R8
    suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && xfer_done && hold) |=> !xfer_active);
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && hold) |=> !bus_req);
    // R3
    ack_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_active) |-> $past(bus_ack));
endmodule

// File: rtl/dma_hold_arbiter.sv
module dma_hold_arbiter #(
    parameter int NCH   = 8,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   chan_req,
    input  logic             xfer_done,
    input  logic             xfer_last,
    input  logic             irq_valid,
    input  logic [LVL_W-1:0] irq_level,
    input  logic             reg_we,
    input  logic             reg_addr,
    input  logic [LVL_W-1:0] reg_wdata,
    input  logic             bus_ack,
    output logic             bus_req,
    output logic [NCH-1:0]   grant,
    output logic             xfer_active
);
    localparam logic [NCH-1:0] ONE = {{(NCH-1){1'b0}}, 1'b1};

    logic           hold;
    logic [NCH-1:0] pick;

    dha_ctrl_regs #(.LVL_W(LVL_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .irq_valid(irq_valid), .irq_level(irq_level),
        .hold(hold)
    );

    dha_prio_pick #(.NCH(NCH)) i_pick (
        .req(chan_req), .pick(pick)
    );

    dha_seq_fsm #(.NCH(NCH)) i_fsm (
        .clk(clk), .rst_n(rst_n), .any_req(|chan_req), .pick(pick),
        .hold(hold), .bus_ack(bus_ack), .xfer_done(xfer_done),
        .xfer_last(xfer_last), .bus_req(bus_req), .grant(grant),
        .xfer_active(xfer_active)
    );

    // R1
    prio_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_active) |-> (((grant - ONE) & $past(chan_req)) == '0));
endmodule

// File: tb/test_dma_hold_arbiter.sv
module test_dma_hold_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int LVL_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] chan_req = '0;
    logic xfer_done = 1'b0, xfer_last = 1'b0, irq_valid = 1'b0;
    logic [LVL_W-1:0] irq_level = '0;
    logic reg_we = 1'b0, reg_addr = 1'b0;
    logic [LVL_W-1:0] reg_wdata = '0;
    logic bus_ack = 1'b0;
    logic bus_req, xfer_active;
    logic [NCH-1:0] grant;

    int total = 0, bad = 0;

    // reference model state: 0 idle, 1 ask, 2 xfer, 3 give
    int m_st = 0;
    logic [NCH-1:0] m_g = '0;
    logic [LVL_W-1:0] m_thr = 5'd31, m_sw = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_hold_arbiter #(.NCH(NCH), .LVL_W(LVL_W)) i_dma_hold_arbiter (
        .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .xfer_done(xfer_done),
        .xfer_last(xfer_last), .irq_valid(irq_valid), .irq_level(irq_level),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .bus_ack(bus_ack), .bus_req(bus_req), .grant(grant),
        .xfer_active(xfer_active)
    );

    function automatic logic [NCH-1:0] low_bit(input logic [NCH-1:0] r);
        for (int i = 0; i < NCH; i++) if (r[i]) return NCH'(1) << i;
        return '0;
    endfunction

    function automatic logic m_hold();
        return (irq_valid && irq_level < m_thr) || (m_sw != '0);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        logic h;
        @(posedge clk);
        h = m_hold();
        if (!rst_n) begin
            m_st = 0; m_g = '0; m_thr = 5'd31; m_sw = '0;
        end else begin
            case (m_st)
                0: if (|chan_req && !h) m_st = 1;
                1: if (h) m_st = 3;
                   else if (bus_ack) begin
                       if (|chan_req) begin m_st = 2; m_g = low_bit(chan_req); end
                       else m_st = 3;
                   end
                2: if (xfer_done && (xfer_last || h)) begin m_st = 3; m_g = '0; end
                default: if (!bus_ack) m_st = 0;
            endcase
            if (reg_we) begin
                if (!reg_addr) m_thr = reg_wdata; else m_sw = reg_wdata;
            end
        end
        @(negedge clk);
        check("R4 bus_req", 32'(bus_req), 32'(m_st == 1 || m_st == 2));
        check("R1 grant", 32'(grant), 32'(m_st == 2 ? m_g : '0));
        check("R8 xfer_active", 32'(xfer_active), 32'(m_st == 2));
        bus_ack = (m_st == 1 || m_st == 2);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic a, input logic [LVL_W-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic pulse(input logic last);
        xfer_done = 1'b1; xfer_last = last;
        step();
        xfer_done = 1'b0; xfer_last = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        steps(3);
        check("R10 reset bus_req", 32'(bus_req), 0);
        check("R10 reset grant", 32'(grant), 0);
        check("R10 reset active", 32'(xfer_active), 0);
        @(negedge clk); rst_n = 1'b1;
        chan_req = 8'h01; steps(2);
        check("R10 idle after reset", 32'(bus_req), 1);
        steps(3); pulse(1'b1); chan_req = '0; steps(3);

        // R6: threshold resets to 31
        irq_valid = 1'b1; irq_level = 5'd30; chan_req = 8'h01; steps(4);
        check("R6 level 30 holds", 32'(bus_req), 0);
        irq_level = 5'd31; steps(4);
        check("R6 level 31 passes", 32'(xfer_active), 1);
        check("R3 granted after ack", 32'(grant), 32'h01);
        pulse(1'b1);
        check("R4 release gap", 32'(bus_req), 0);
        chan_req = '0; irq_valid = 1'b0; steps(3);

        // R1 / R2 priority and hold of grant
        chan_req = 8'hA4; steps(4);
        check("R1 picks bit2", 32'(grant), 32'h04);
        chan_req = 8'hA5; steps(2);
        check("R2 grant kept", 32'(grant), 32'h04);
        pulse(1'b0);
        check("R2 non-last keeps", 32'(grant), 32'h04);
        pulse(1'b1); chan_req = 8'hA1; steps(4);
        check("R1 next picks bit0", 32'(grant), 32'h01);

        // R8 suspend on interrupt, R9 idle hold
        irq_valid = 1'b1; irq_level = 5'd3; pulse(1'b0);
        check("R8 suspended", 32'(xfer_active), 0);
        steps(3);
        check("R9 no request under hold", 32'(bus_req), 0);
        irq_valid = 1'b0; steps(4);
        check("R8 resumed", 32'(grant), 32'h01);

        // R7 software hold
        wr(1'b1, 5'd2); pulse(1'b0); steps(3);
        check("R7 software hold", 32'(bus_req), 0);
        wr(1'b1, 5'd0); steps(4);
        check("R7 released", 32'(grant), 32'h01);

        // R5 threshold comparison boundary
        wr(1'b0, 5'd10); irq_valid = 1'b1; irq_level = 5'd10; pulse(1'b0);
        check("R5 equal level no hold", 32'(xfer_active), 1);
        irq_level = 5'd9; pulse(1'b0);
        check("R5 lower level holds", 32'(xfer_active), 0);
        irq_valid = 1'b0; chan_req = '0; steps(4);

        // constrained random phase
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 9) == 0) chan_req = NCH'($urandom);
            xfer_done = ($urandom_range(0, 2) == 0);
            xfer_last = ($urandom_range(0, 3) == 0);
            irq_valid = ($urandom_range(0, 7) == 0);
            irq_level = LVL_W'($urandom);
            reg_we = ($urandom_range(0, 40) == 0);
            reg_addr = $urandom_range(0, 1);
            reg_wdata = (reg_addr && $urandom_range(0, 1) == 0) ? '0 : LVL_W'($urandom);
            step();
        end
        reg_we = 1'b0; xfer_done = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule